// File: doc/BRIEF.md
# Soft-Reset and Clock-Gate Control Register

This block is the control word a peripheral exposes to the software routine that brings it in and out of reset. It is a 32-bit register. The top bit holds the peripheral core in reset, and the next bit below it stops the core's clock. The remaining thirty bits are ordinary storage. The two outputs, `core_rst` and `core_clk_en`, follow the two control bits directly.

Software puts the core into reset by writing the top bit to one. The register models the time the core needs to finish its internal reset with a counter, `RESET_CYCLES` cycles long. When that time is up, the hardware sets the gate bit by itself, so the core ends up both reset and gated. To bring the core back, software clears the reset bit and then clears the gate bit. Each bit reads back as zero once it has taken effect. At power-on both bits are set, so the core starts held in reset with its clock stopped.

Top module: `srst_gate_ctl`

## Requirements
- R1: After power-on reset, `rd_data` reads 0xC000_0000 (bit 31 = 1, bit 30 = 1, bits 29..0 = 0), `core_rst` is 1 and `core_clk_en` is 0.
- R2: A write with bit 31 = 0 makes bit 31 read 0 from the next cycle, and `core_rst` drops in that same cycle.
- R3: A write with bit 30 = 0 makes bit 30 read 0 from the next cycle, and `core_clk_en` rises in that same cycle. A write with bit 30 = 1 gates the clock.
- R4: A write with bit 31 = 1 makes bit 31 read 1 and raises `core_rst` from the next cycle.
- R5: When a write moves bit 31 from 0 to 1, the hardware sets bit 30 exactly `RESET_CYCLES` clock edges after that write's edge, and not before.
- R6: Bit 30 is set by hardware only once per entry into reset. A later software clear of bit 30 while bit 31 stays 1 is kept. A repeated write of bit 31 = 1 while it is already 1 neither restarts nor moves the completion time.
- R7: Bits 29..0 hold the value last written and are never changed by the reset or gate sequence.
- R8: Clearing bit 31 before the completion time cancels the pending completion, so bit 30 is not set by hardware.
- R9: `core_rst` always equals bit 31 of `rd_data`, and `core_clk_en` always equals the inverse of bit 30.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low power-on reset, asynchronous |
| wr_en | input | 1 | Write strobe; `wr_data` is loaded on this edge |
| wr_data | input | 32 | Write value; bit 31 is reset, bit 30 is gate, bits 29..0 are storage |
| rd_data | output | 32 | Current register contents |
| core_rst | output | 1 | Reset to the peripheral core, active high |
| core_clk_en | output | 1 | Clock enable for the peripheral core |

## Verification
The bench checks the edge on which the gate bit turns on, one edge early and on the exact edge. A counter that is off by one would show the bit set early or late. It cancels a pending reset partway through and watches bit 30 for many cycles. A design that fails to drop the pending completion would set the gate anyway. It clears the gate bit while reset is still held, and it rewrites the reset bit in the middle of the countdown. A design that re-arms on every write would set bit 30 again or move its rising edge. Across all of these the low thirty bits are compared, which catches any sequence logic that disturbs the storage bits.

// File: rtl/srst_gate_ctl.sv
module srst_gate_ctl #(
  parameter int RESET_CYCLES = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  output logic        core_rst,
  output logic        core_clk_en
);

  localparam int CW = $clog2(RESET_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(RESET_CYCLES - 1);

  logic          rst_bit;
  logic          gate_bit;
  logic [29:0]   store;
  logic [CW-1:0] cnt;
  logic          pending;
  logic          done_now;
  logic          arm;

  assign done_now = pending && rst_bit && (cnt == LAST);
  assign arm      = wr_en && wr_data[31] && !rst_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_bit  <= 1'b1;
      gate_bit <= 1'b1;
      store    <= '0;
      cnt      <= '0;
      pending  <= 1'b0;
    end else begin
      if (wr_en) begin
        store    <= wr_data[29:0];
        rst_bit  <= wr_data[31];
        gate_bit <= wr_data[30] | done_now;
      end else if (done_now) begin
        gate_bit <= 1'b1;
      end

      if (arm) begin
        pending <= 1'b1;
        cnt     <= '0;
      end else if (wr_en && !wr_data[31]) begin
        pending <= 1'b0;
      end else if (done_now) begin
        pending <= 1'b0;
      end else if (pending) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign rd_data     = {rst_bit, gate_bit, store};
  assign core_rst    = rst_bit;
  assign core_clk_en = ~gate_bit;

  assert_clear_rst_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !wr_data[31] |=> !rd_data[31] && !core_rst);

  assert_enter_rst_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_data[31] |=> core_rst);

  assert_clear_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !wr_data[30] && !done_now |=> core_clk_en);

  assert_storage_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data[29:0] == $past(wr_data[29:0]));

  assert_storage_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(rd_data[29:0]));

  assert_gate_only_in_rst_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en && !core_rst |=> $stable(rd_data[30]));

  assert_no_rearm_R6: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst && !pending && !wr_en |=> $stable(rd_data[30]));

  assert_outputs_R9: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst == rd_data[31] && core_clk_en == !rd_data[30]);

endmodule

// File: tb/srst_gate_ctl_test.sv
module srst_gate_ctl_test;

  localparam int DLY = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        core_rst, core_clk_en;

  srst_gate_ctl #(.RESET_CYCLES(DLY)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .core_rst(core_rst), .core_clk_en(core_clk_en)
  );

  always #10 clk = ~clk;

  typedef struct {
    int          cyc;
    logic [31:0] val;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   cycle = 0;
  int   tests = 0;
  int   fails = 0;
  bit   done = 0;

  always @(posedge clk) cycle <= cycle + 1;

  task automatic op(input bit we, input logic [31:0] d, input logic [31:0] e, input string tag);
    exp_t x;
    @(posedge clk);
    #2;
    wr_en   = we;
    wr_data = d;
    x.cyc = cycle + 1;
    x.val = e;
    x.tag = tag;
    q.push_back(x);
  endtask

  task automatic idle(input int n, input logic [31:0] e, input string tag);
    for (int i = 0; i < n; i++) op(1'b0, 32'h0, e, tag);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #5;
      while (q.size() > 0 && q[0].cyc == cycle) begin
        exp_t x;
        x = q.pop_front();
        tests++;
        if (rd_data !== x.val || core_rst !== x.val[31] || core_clk_en !== ~x.val[30]) begin
          fails++;
          $display("FAIL %s: rd=%h rst=%b clken=%b expected rd=%h rst=%b clken=%b",
                   x.tag, rd_data, core_rst, core_clk_en, x.val, x.val[31], ~x.val[30]);
        end
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    // R1 and R9: power-on state
    op(1'b0, 32'h0, 32'hC000_0000, "R1 power-on");
    op(1'b1, 32'h4000_1234, 32'h4000_1234, "R2 clear reset bit");
    op(1'b1, 32'h0000_1234, 32'h0000_1234, "R3 clear gate bit");
    // R4, R5: enter reset, gate appears after DLY edges
    op(1'b1, 32'h8000_5678, 32'h8000_5678, "R4 enter reset");
    idle(DLY - 1, 32'h8000_5678, "R5 gate not early");
    idle(1, 32'hC000_5678, "R5 gate on time");
    idle(4, 32'hC000_5678, "R7 storage held");
    // R6: software clears gate while reset is held; stays cleared
    op(1'b1, 32'h8000_5678, 32'h8000_5678, "R6 clear gate in reset");
    idle(DLY + 2, 32'h8000_5678, "R6 gate set once");
    op(1'b1, 32'h0000_5678, 32'h0000_5678, "R2 leave reset");
    // R8: cancel a pending completion
    op(1'b1, 32'h8000_ABCD, 32'h8000_ABCD, "R4 re-enter reset");
    idle(3, 32'h8000_ABCD, "R5 counting");
    op(1'b1, 32'h0000_ABCD, 32'h0000_ABCD, "R8 cancel");
    idle(DLY + 2, 32'h0000_ABCD, "R8 no gate after cancel");
    // R6: rewrite of reset bit does not restart countdown
    op(1'b1, 32'h8000_0001, 32'h8000_0001, "R4 enter reset again");
    idle(3, 32'h8000_0001, "R5 counting");
    op(1'b1, 32'h8000_0002, 32'h8000_0002, "R6 rewrite reset bit");
    idle(DLY - 5, 32'h8000_0002, "R6 no restart early");
    idle(1, 32'hC000_0002, "R6 original completion time");
    // R3 and R7: gate by software, full storage patterns
    op(1'b1, 32'h7FFF_FFFF, 32'h7FFF_FFFF, "R3 software gate");
    op(1'b1, 32'h3FFF_FFFF, 32'h3FFF_FFFF, "R7 all ones storage");
    op(1'b1, 32'h2AAA_AAAA, 32'h2AAA_AAAA, "R7 pattern storage");
    idle(2, 32'h2AAA_AAAA, "R9 idle outputs");
    @(posedge clk);
    @(posedge clk);
    #8;
    done = 1;
  end

  initial begin
    int wd = 0;
    while (!done && wd < 5000) begin
      @(posedge clk);
      wd++;
    end
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule